// File: doc/BRIEF.md
# Actuator Startup and Move Sequencer

This block is the control state machine of a piezo actuator driver. It decides how many drive periods run and in which direction. It counts the period-end pulse of a separate waveform generator, and that generator's time base is counted in every phase, including phases with no drive. The bus slave and the waveform timing lie outside this block. They reach it only as a command write strobe carrying a direction bit and a pulse count, plus a set of static configuration fields: the step setting, the homing enable, the homing length and the swing-back selection.

A group is `step_m1 + 1` periods, and every length the sequencer measures is a whole number of groups. When enable rises, the block can run a homing routine. The routine first makes a long move in the stored direction. It then pauses with the drive off. Last, it makes a short swing-back in the opposite direction. After homing, or straight away when homing is off, the block carries out move commands and adds their counts to a pending total. A command that reverses the direction replaces the pending total. A test-continuous input keeps the actuator running toward infinity for as long as it is held high.

The block has three outputs. `busy` tells the host that the sequencer is doing something. `run` gates the drive waveform. `dir_out` selects the waveform polarity: 0 means toward infinity and 1 means toward macro.

Top module: `piezo_move_seq`

## Requirements
- R1: After the synchronous reset, `busy`, `run` and `dir_out` are all 0, and the stored direction is 0 (toward infinity).
- R2: With enable high and the block idle, a command write of count P sets `busy` and `run` on the next cycle, with `dir_out` equal to the command's direction bit. Both outputs fall on the edge that samples the P·(step_m1+1)-th period-end pulse.
- R3: A command in the stored direction adds its count to the pending total of pulses, and the total is capped at 512.
- R4: A command whose direction bit differs from the stored direction replaces the pending total with its own count and restarts the current group. A reversing command with count 0 makes the block idle on the next cycle.
- R5: On a rising edge of enable with `home_skip` = 0, the block drives in the stored direction for 16·(home_len+1) groups. With `home_skip` = 1, the rising edge starts nothing.
- R6: After the forward homing move, the block holds `run` low and `busy` high for 4 groups. It then drives in the opposite direction for the swing-back count: `swing_sel` 00 gives 2 groups, 01 gives 1, 10 gives 3 and 11 gives 4. After that it goes idle.
- R7: With enable low, `busy` and `run` are 0 from the next cycle and the pending total is cleared. Command writes made while enable is low only update the stored direction.
- R8: With enable and `cont_mode` both high, `busy` and `run` are 1 and `dir_out` is 0 from the next cycle, and no number of period-end pulses ends this.
- R9: A command written during homing is held. Its move starts when the swing-back ends, without `busy` dropping.
- R10: Reset clears the pending total, the stored direction and the sampled enable level, and returns the block to idle.
- R11: A command write and a group end in the same cycle both take effect: one pulse is consumed and the new count is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; a rising edge may start homing, and low forces standby |
| cont_mode | input | 1 | Test-continuous drive toward infinity |
| period_tick | input | 1 | One-cycle pulse at each drive period end |
| cmd_wr | input | 1 | Command write strobe |
| cmd_dir | input | 1 | Command direction, 0 infinity, 1 macro |
| cmd_pulses | input | 7 | Command pulse count (0 to 127) |
| step_m1 | input | 8 | Periods per group minus one |
| home_skip | input | 1 | 1 disables homing on enable |
| home_len | input | 4 | Homing length code n, 16·(n+1) groups |
| swing_sel | input | 2 | Swing-back group count select |
| busy | output | 1 | Sequencer active |
| run | output | 1 | Drive waveform gate |
| dir_out | output | 1 | Drive direction, 0 infinity, 1 macro |

## Verification
Two events can coincide in one cycle: a command write, and the period-end pulse that finishes a group of a running move. The bench provokes this by driving `cmd_wr` and `period_tick` on the same edge after a move has already consumed a group. The expected number of remaining pulses is the pending total minus one, plus the new count, and the bench checks this by counting period-end pulses until `busy` falls. A second overlap is tested too: a command written during the homing pause must lengthen the busy window by exactly its move.

// File: rtl/piezo_seq_pkg.sv
package piezo_seq_pkg;

    localparam int STEP_W      = 8;
    localparam int CNT_W       = 7;
    localparam int HOME_W      = 4;
    localparam int PEND_MAX    = 512;
    localparam int PEND_W      = $clog2(PEND_MAX + 1);
    localparam int WAIT_GROUPS = 4;
    localparam int HOME_UNIT   = 16;

    typedef logic [PEND_W-1:0] grp_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOME_FWD,
        ST_HOME_WAIT,
        ST_HOME_BACK,
        ST_MOVE,
        ST_CONT
    } seq_state_e;

    // groups in the forward homing move: HOME_UNIT * (n + 1)
    function automatic grp_t home_groups(input logic [HOME_W-1:0] n);
        return grp_t'({n, 4'b0000}) + grp_t'(HOME_UNIT);
    endfunction

    // swing-back group count per select code
    function automatic grp_t swing_groups(input logic [1:0] sel);
        case (sel)
            2'b00:   return grp_t'(2);
            2'b01:   return grp_t'(1);
            2'b10:   return grp_t'(3);
            default: return grp_t'(4);
        endcase
    endfunction

    // saturating add of a command count to the pending total
    function automatic grp_t pend_add(input grp_t base, input logic [CNT_W-1:0] add);
        logic [PEND_W:0] sum;
        sum = {1'b0, base} + {{(PEND_W + 1 - CNT_W){1'b0}}, add};
        if (sum > (PEND_W + 1)'(PEND_MAX))
            return grp_t'(PEND_MAX);
        return sum[PEND_W-1:0];
    endfunction

endpackage

// File: rtl/piezo_seq_ticker.sv
module piezo_seq_ticker
    import piezo_seq_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  grp_t          load_groups,
    input  logic          count_en,
    input  logic          tick,
    input  logic [SW-1:0] step_m1,
    output logic          group_done,
    output logic          phase_done
);
    logic [SW-1:0] per_q;
    grp_t          grp_q;

    // a group ends on the tick that completes step_m1+1 periods
    assign group_done = count_en && tick && (per_q >= step_m1);
    assign phase_done = group_done && (grp_q == grp_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
            grp_q <= '0;
        end else if (load) begin
            per_q <= '0;
            grp_q <= load_groups;
        end else if (group_done) begin
            per_q <= '0;
            if (grp_q != '0)
                grp_q <= grp_q - grp_t'(1);
        end else if (count_en && tick) begin
            per_q <= per_q + SW'(1);
        end
    end

    assert_group_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (load || group_done) |=> (per_q == '0));

endmodule

// File: rtl/piezo_seq_queue.sv
module piezo_seq_queue
    import piezo_seq_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          cmd_wr,
    input  logic          cmd_dir,
    input  logic [CW-1:0] cmd_cnt,
    input  logic          consume,
    output grp_t          pend_q,
    output grp_t          pend_nxt,
    output logic          dir_q,
    output logic          flip
);
    grp_t base;

    assign flip = cmd_wr && (cmd_dir != dir_q);

    always_comb begin
        base = pend_q;
        if (consume && (pend_q != '0))
            base = pend_q - grp_t'(1);
        if (clear)
            pend_nxt = '0;
        else if (flip)
            pend_nxt = {{(PEND_W - CW){1'b0}}, cmd_cnt};
        else if (cmd_wr)
            pend_nxt = pend_add(base, cmd_cnt);
        else
            pend_nxt = base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            dir_q  <= 1'b0;
        end else begin
            pend_q <= pend_nxt;
            if (cmd_wr)
                dir_q <= cmd_dir;
        end
    end

    assert_pend_cap_R3: assert property (@(posedge clk) disable iff (rst)
        pend_q <= grp_t'(PEND_MAX));

    assert_flip_replaces_R4: assert property (@(posedge clk) disable iff (rst)
        (flip && !clear) |=> (pend_q == {{(PEND_W - CW){1'b0}}, $past(cmd_cnt)}));

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pend_q == '0));

endmodule

// File: rtl/piezo_move_seq.sv
module piezo_move_seq
    import piezo_seq_pkg::*;
#(
    parameter int SW = STEP_W,
    parameter int CW = CNT_W,
    parameter int HW = HOME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cont_mode,
    input  logic          period_tick,
    input  logic          cmd_wr,
    input  logic          cmd_dir,
    input  logic [CW-1:0] cmd_pulses,
    input  logic [SW-1:0] step_m1,
    input  logic          home_skip,
    input  logic [HW-1:0] home_len,
    input  logic [1:0]    swing_sel,
    output logic          busy,
    output logic          run,
    output logic          dir_out
);
    seq_state_e state, state_nxt;
    logic       en_q;
    logic       home_dir;
    logic       home_start;
    logic       load;
    grp_t       load_grps;
    logic       count_en;
    logic       group_done, phase_done;
    logic       consume;
    grp_t       pend_q, pend_nxt;
    logic       dir_q, flip;

    assign count_en = (state == ST_HOME_FWD) || (state == ST_HOME_WAIT) ||
                      (state == ST_HOME_BACK) || (state == ST_MOVE);
    assign consume  = (state == ST_MOVE) && group_done;

    piezo_seq_ticker #(.SW(SW)) u_ticker (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_groups (load_grps),
        .count_en    (count_en),
        .tick        (period_tick),
        .step_m1     (step_m1),
        .group_done  (group_done),
        .phase_done  (phase_done)
    );

    piezo_seq_queue #(.CW(CW)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .clear    (!en),
        .cmd_wr   (cmd_wr),
        .cmd_dir  (cmd_dir),
        .cmd_cnt  (cmd_pulses),
        .consume  (consume),
        .pend_q   (pend_q),
        .pend_nxt (pend_nxt),
        .dir_q    (dir_q),
        .flip     (flip)
    );

    always_comb begin
        state_nxt  = state;
        load       = 1'b0;
        load_grps  = '0;
        home_start = 1'b0;
        if (!en) begin
            state_nxt = ST_IDLE;
        end else if (cont_mode) begin
            state_nxt = ST_CONT;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!en_q && !home_skip) begin
                        state_nxt  = ST_HOME_FWD;
                        load       = 1'b1;
                        load_grps  = home_groups(home_len);
                        home_start = 1'b1;
                    end else if (pend_nxt != '0) begin
                        state_nxt = ST_MOVE;
                        load      = 1'b1;
                    end
                end
                ST_HOME_FWD: begin
                    if (phase_done) begin
                        state_nxt = ST_HOME_WAIT;
                        load      = 1'b1;
                        load_grps = grp_t'(WAIT_GROUPS);
                    end
                end
                ST_HOME_WAIT: begin
                    if (phase_done) begin
                        state_nxt = ST_HOME_BACK;
                        load      = 1'b1;
                        load_grps = swing_groups(swing_sel);
                    end
                end
                ST_HOME_BACK: begin
                    if (phase_done) begin
                        load = 1'b1;
                        state_nxt = (pend_nxt != '0) ? ST_MOVE : ST_IDLE;
                    end
                end
                ST_MOVE: begin
                    if (pend_nxt == '0)
                        state_nxt = ST_IDLE;
                    else if (flip)
                        load = 1'b1;
                end
                ST_CONT:  state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            en_q     <= 1'b0;
            home_dir <= 1'b0;
        end else begin
            state <= state_nxt;
            en_q  <= en;
            if (home_start)
                home_dir <= dir_q;
        end
    end

    assign busy = (state != ST_IDLE);

    always_comb begin
        run     = 1'b0;
        dir_out = dir_q;
        case (state)
            ST_HOME_FWD:  begin run = 1'b1; dir_out = home_dir;  end
            ST_HOME_BACK: begin run = 1'b1; dir_out = !home_dir; end
            ST_MOVE:      run = 1'b1;
            ST_CONT:      begin run = 1'b1; dir_out = 1'b0;      end
            default:      run = 1'b0;
        endcase
    end

    assert_home_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !en_q && !home_skip && !cont_mode && state == ST_IDLE)
        |=> (busy && run && dir_out == $past(dir_q)));

    assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOME_FWD && phase_done && en && !cont_mode) |=> (busy && !run));

    assert_standby_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && !run));

    assert_continuous_R8: assert property (@(posedge clk) disable iff (rst)
        (en && cont_mode) |=> (busy && run && !dir_out));

    assert_queued_move_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOME_BACK && phase_done && en && !cont_mode && pend_nxt != '0)
        |=> (busy && run && dir_out == $past(pend_nxt != '0 ? dir_q : dir_q)));

endmodule

// File: tb/piezo_move_seq_test.sv
module piezo_move_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 5000;

    logic       clk = 1'b0;
    logic       rst, en, cont_mode, period_tick, cmd_wr, cmd_dir, home_skip;
    logic [6:0] cmd_pulses;
    logic [7:0] step_m1;
    logic [3:0] home_len;
    logic [1:0] swing_sel;
    logic       busy, run, dir_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    logic bdir;

    always #(CLK_PERIOD/2) clk = ~clk;

    piezo_move_seq uut (
        .clk(clk), .rst(rst), .en(en), .cont_mode(cont_mode), .period_tick(period_tick),
        .cmd_wr(cmd_wr), .cmd_dir(cmd_dir), .cmd_pulses(cmd_pulses), .step_m1(step_m1),
        .home_skip(home_skip), .home_len(home_len), .swing_sel(swing_sel),
        .busy(busy), .run(run), .dir_out(dir_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int swing_exp(input int sel);
        case (sel)
            0: return 2;
            1: return 1;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int home_exp(input int n);
        return 16 * (n + 1);
    endfunction

    task automatic pulse_tick();
        @(negedge clk) period_tick = 1'b1;
        @(negedge clk) period_tick = 1'b0;
    endtask

    task automatic wr(input logic d, input int cnt);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_dir = d; cmd_pulses = 7'(cnt);
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic ticks_busy(input logic want, output int n);
        n = 0;
        while (busy !== want && n < LIMIT) begin
            pulse_tick();
            n++;
        end
    endtask

    task automatic ticks_run(input logic want, output int n);
        n = 0;
        while (run !== want && n < LIMIT) begin
            pulse_tick();
            n++;
        end
    endtask

    task automatic idle_cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n, s, p, q, hn, sel;
        logic hd;
        void'($urandom(32'd20240611));
        rst = 1'b1; en = 1'b0; cont_mode = 1'b0; period_tick = 1'b0;
        cmd_wr = 1'b0; cmd_dir = 1'b0; cmd_pulses = '0; step_m1 = '0;
        home_skip = 1'b1; home_len = '0; swing_sel = '0;
        idle_cycles(3);
        rst = 1'b0;
        idle_cycles(1);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 run", run, 0);
        chk("R1 dir", dir_out, 0);
        bdir = 1'b0;

        // R5 skip: enable rise with homing off starts nothing
        en = 1'b1;
        idle_cycles(2);
        chk("R5 skip busy", busy, 0);

        // R2 random moves
        for (int i = 0; i < 5; i++) begin
            s = $urandom % 4;
            p = 1 + $urandom % 6;
            step_m1 = 8'(s);
            bdir = 1'($urandom % 2);
            wr(bdir, p);
            chk("R2 busy start", busy, 1);
            chk("R2 run start", run, 1);
            chk("R2 dir", dir_out, int'(bdir));
            ticks_busy(1'b0, n);
            chk("R2 period count", n, p * (s + 1));
            chk("R2 run end", run, 0);
        end

        // R3 accumulate in same direction
        step_m1 = 8'd1;
        wr(bdir, 3);
        wr(bdir, 4);
        ticks_busy(1'b0, n);
        chk("R3 accumulate", n, 7 * 2);
        // R3 cap at 512
        step_m1 = 8'd0;
        for (int i = 0; i < 5; i++) wr(bdir, 127);
        ticks_busy(1'b0, n);
        chk("R3 cap 512", n, 512);

        // R11 write and group end in the same cycle
        step_m1 = 8'd0;
        p = 2 + $urandom % 5;
        q = 1 + $urandom % 5;
        wr(bdir, p);
        pulse_tick();
        @(negedge clk);
        period_tick = 1'b1; cmd_wr = 1'b1; cmd_dir = bdir; cmd_pulses = 7'(q);
        @(negedge clk);
        period_tick = 1'b0; cmd_wr = 1'b0;
        ticks_busy(1'b0, n);
        chk("R11 coincident write", n, p - 2 + q);

        // R4 reversal replaces pending and restarts the group
        step_m1 = 8'd2;
        wr(bdir, 5);
        pulse_tick();
        q = 1 + $urandom % 4;
        bdir = !bdir;
        wr(bdir, q);
        chk("R4 dir after reversal", dir_out, int'(bdir));
        ticks_busy(1'b0, n);
        chk("R4 reversal count", n, q * 3);
        // R4 reversal with zero stops
        wr(bdir, 6);
        pulse_tick();
        bdir = !bdir;
        wr(bdir, 0);
        chk("R4 zero reversal stops", busy, 0);
        pulse_tick();
        chk("R4 stays stopped", busy, 0);

        // R7 enable low stops and clears; writes only set direction
        step_m1 = 8'd1;
        wr(bdir, 4);
        pulse_tick();
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk("R7 busy low", busy, 0);
        chk("R7 run low", run, 0);
        bdir = !bdir;
        wr(bdir, 5);
        home_skip = 1'b1;
        @(negedge clk) en = 1'b1;
        idle_cycles(2);
        chk("R7 pending cleared", busy, 0);
        chk("R7 direction stored", dir_out, int'(bdir));

        // R5 R6 homing with random lengths
        for (int i = 0; i < 3; i++) begin
            hn = $urandom % 3;
            sel = $urandom % 4;
            s = $urandom % 2;
            hd = 1'($urandom % 2);
            @(negedge clk) en = 1'b0;
            wr(hd, 1);
            bdir = hd;
            step_m1 = 8'(s); home_len = 4'(hn); swing_sel = 2'(sel); home_skip = 1'b0;
            @(negedge clk) en = 1'b1;
            @(negedge clk);
            chk("R5 home busy", busy, 1);
            chk("R5 home run", run, 1);
            chk("R5 home dir", dir_out, int'(hd));
            ticks_run(1'b0, n);
            chk("R5 forward length", n, home_exp(hn) * (s + 1));
            chk("R6 busy in pause", busy, 1);
            ticks_run(1'b1, n);
            chk("R6 pause length", n, 4 * (s + 1));
            chk("R6 back dir", dir_out, int'(!hd));
            ticks_busy(1'b0, n);
            chk("R6 swing length", n, swing_exp(sel) * (s + 1));
        end

        // R9 command during pause is held until homing ends
        hn = 0; sel = $urandom % 4; s = 1;
        @(negedge clk) en = 1'b0;
        step_m1 = 8'(s); home_len = 4'(hn); swing_sel = 2'(sel); home_skip = 1'b0;
        @(negedge clk) en = 1'b1;
        @(negedge clk);
        ticks_run(1'b0, n);
        p = 1 + $urandom % 4;
        wr(bdir, p);
        chk("R9 still pausing", run, 0);
        ticks_run(1'b1, n);
        chk("R9 pause unchanged", n, 4 * (s + 1));
        ticks_busy(1'b0, n);
        chk("R9 swing plus queued", n, (swing_exp(sel) + p) * (s + 1));

        // R8 continuous drive
        home_skip = 1'b1;
        @(negedge clk) cont_mode = 1'b1;
        @(negedge clk);
        chk("R8 busy", busy, 1);
        chk("R8 run", run, 1);
        chk("R8 dir", dir_out, 0);
        repeat (8) pulse_tick();
        chk("R8 ticks ignored", busy, 1);
        @(negedge clk) cont_mode = 1'b0;
        @(negedge clk);
        chk("R8 release", busy, 0);

        // R10 reset mid move
        step_m1 = 8'd1;
        wr(1'b1, 5);
        pulse_tick();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R10 busy cleared", busy, 0);
        chk("R10 dir cleared", dir_out, 0);
        pulse_tick();
        chk("R10 pending cleared", busy, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule